// File: doc/BRIEF.md
# Lane-Partitioned Packed Adder

This block is a 64-bit adder whose carry chain is cut into 8-bit segments. A mode input chooses how the segments are grouped into lanes. The grouping can be one full-width lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Every lane adds its own slice of the two operands in the same cycle, and no carry passes from one lane into the next. This lets one operation process packed small data, such as 8-bit colour components or 16-bit audio samples, as well as ordinary 64-bit integers.

Two controls change the operation. The subtract control inverts operand B and injects a carry of one into the bottom of every lane, so each lane computes A minus B. The saturate control clamps each lane to its unsigned limits when that lane overflows or borrows. The packed result and one carry bit per 8-bit segment are registered, so they appear one clock after the operands are sampled.

Top module: `spa_lane_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sum_o` and `carry_o` are cleared to zero at that edge.
- R2: The inputs are sampled at a rising edge, and the result for them appears on `sum_o` and `carry_o` after that edge. The outputs do not change between edges.
- R3: With `mode_i` = 2'b00, `sum_o` = (A + B) mod 2^64. Bit `carry_o[i]` is the carry out of bit 8i+7 of that single chain, so `carry_o[7]` is the carry out of bit 63.
- R4: With `mode_i` = 2'b11, each byte k of `sum_o` (bits 8k+7..8k) is the 8-bit sum of byte k of A and byte k of B, and `carry_o[k]` is that byte's carry out.
- R5: With `mode_i` = 2'b01, the operands form four 16-bit lanes over segment pairs 2k and 2k+1. `carry_o[2k+1]` is the lane carry out and `carry_o[2k]` is the carry out of the lane's low byte.
- R6: With `mode_i` = 2'b10, the operands form two 32-bit lanes over segments 0..3 and 4..7. `carry_o[3]` and `carry_o[7]` are the lane carries, and the other bits are carries inside each lane.
- R7: No carry crosses a lane boundary. The carry into the lowest bit of every lane equals `sub_i`, whatever the lane below produces.
- R8: With `sub_i` = 1, every lane computes (A - B) mod 2^w as A + ~B + 1. The lane-top carry bit is 1 exactly when the lane's A is at least its B (no borrow).
- R9: With `sat_i` = 1 and `sub_i` = 0, every lane whose top carry is 1 outputs all ones. `carry_o` still reports the raw carries.
- R10: With `sat_i` = 1 and `sub_i` = 1, every lane whose top carry is 0 (a borrow) outputs zero. `carry_o` still reports the raw carries.
- R11: `sat_i` does not change any lane that neither overflows (add) nor borrows (subtract).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Lane grouping: 00 full width, 01 16-bit, 10 32-bit, 11 8-bit |
| sub_i | input | 1 | 1 selects A minus B in every lane |
| sat_i | input | 1 | 1 selects unsigned saturating results per lane |
| a_i | input | 64 | Operand A, packed |
| b_i | input | 64 | Operand B, packed |
| sum_o | output | 64 | Registered packed result |
| carry_o | output | 8 | Registered carry out of each 8-bit segment |

## Verification
Both `sum_o` and `carry_o` belong to the operands and controls sampled at one rising edge, and they are visible after that edge. The bench therefore drives each vector on a falling edge and compares on the next falling edge, one full edge after capture. It also compares just after driving, before the capturing edge, to confirm that the old result still holds. The in-RTL properties use the same relation: each property compares the present registered outputs with the `$past` values of the inputs.

// File: rtl/spa_pkg.sv
// Package: shared lane-mode type and the lane-boundary rule for the
// partitioned adder. Assumes lanes are 1, 2, 4 or all segments wide.
package spa_pkg;

    typedef enum logic [1:0] {
        LANE_FULL = 2'b00,
        LANE_16   = 2'b01,
        LANE_32   = 2'b10,
        LANE_8    = 2'b11
    } lane_mode_e;

    // Number of 8-bit segments grouped into one lane for a mode.
    function automatic int unsigned segs_per_lane(input lane_mode_e m, input int unsigned nseg);
        case (m)
            LANE_8:  return 1;
            LANE_16: return 2;
            LANE_32: return 4;
            default: return nseg;
        endcase
    endfunction

    // True when segment idx is the lowest segment of a lane.
    function automatic logic seg_starts_lane(input lane_mode_e m, input int unsigned idx,
                                             input int unsigned nseg);
        return (idx % segs_per_lane(m, nseg)) == 0;
    endfunction

endpackage

// File: rtl/spa_boundary_ctl.sv
// Module: spa_boundary_ctl
// Decodes the lane mode into two masks over the segments: which segments
// begin a lane (their carry-in is forced) and which segments end a lane
// (their carry-out is the lane carry). Purely combinational.
// Assumes NSEG is a multiple of 4 so every mode tiles the word exactly.
module spa_boundary_ctl
    import spa_pkg::*;
#(
    parameter int NSEG = 8
) (
    input  lane_mode_e       mode,
    output logic [NSEG-1:0]  start_mask,
    output logic [NSEG-1:0]  top_mask
);

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        // Lane start: carry-in of this segment comes from the control, not below.
        assign start_mask[i] = seg_starts_lane(mode, i, NSEG);
        if (i == NSEG - 1) begin : g_last
            // The top segment always closes a lane.
            assign top_mask[i] = 1'b1;
        end else begin : g_inner
            // A segment closes a lane when the next one opens a new lane.
            assign top_mask[i] = seg_starts_lane(mode, i + 1, NSEG);
        end
    end

endmodule

// File: rtl/spa_seg_adder.sv
// Module: spa_seg_adder
// One SEG_W-bit ripple segment of the partitioned chain: sum and carry-out
// of two segment slices plus a carry-in. Combinational; the caller chooses
// whether carry-in comes from the segment below or from the lane control.
module spa_seg_adder #(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0] a,
    input  logic [SEG_W-1:0] b,
    input  logic             cin,
    output logic [SEG_W-1:0] sum,
    output logic             cout
);

    logic [SEG_W:0] wide;

    // Widened add keeps the segment carry as the extra top bit.
    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin};
    end

    assign sum  = wide[SEG_W-1:0];
    assign cout = wide[SEG_W];

endmodule

// File: rtl/spa_lane_sat.sv
// Module: spa_lane_sat
// Applies unsigned saturation per lane. Each segment looks up the carry of
// the top segment of its own lane; on overflow (add) the segment becomes all
// ones, on borrow (subtract) it becomes zero. With sat_en low the raw sum
// passes unchanged. Assumes top_mask marks exactly the lane-top segments.
module spa_lane_sat #(
    parameter int NSEG  = 8,
    parameter int SEG_W = 8,
    localparam int W    = NSEG * SEG_W
) (
    input  logic [W-1:0]    raw_sum,
    input  logic [NSEG-1:0] seg_carry,
    input  logic [NSEG-1:0] top_mask,
    input  logic            sat_en,
    input  logic            sub_en,
    output logic [W-1:0]    sat_sum
);

    logic [NSEG-1:0] lane_carry;

    // Spread each lane-top carry down to every segment of that lane.
    always_comb begin
        logic run;
        run = seg_carry[NSEG-1];
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (top_mask[i]) run = seg_carry[i];
            lane_carry[i] = run;
        end
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_clamp
        logic ceiling;
        logic floor_hit;
        // Clamp decision for this segment from its lane's carry.
        always_comb begin
            ceiling   = sat_en && !sub_en && lane_carry[i];
            floor_hit = sat_en &&  sub_en && !lane_carry[i];
        end
        // Select clamp value or pass-through for this segment.
        always_comb begin
            if (ceiling)        sat_sum[i*SEG_W +: SEG_W] = {SEG_W{1'b1}};
            else if (floor_hit) sat_sum[i*SEG_W +: SEG_W] = {SEG_W{1'b0}};
            else                sat_sum[i*SEG_W +: SEG_W] = raw_sum[i*SEG_W +: SEG_W];
        end
    end

endmodule

// File: rtl/spa_lane_adder.sv
// Module: spa_lane_adder (top)
// Packed adder with a segmented carry chain. The mode groups NSEG segments
// of SEG_W bits into lanes; carry is cut at every lane start and replaced by
// the subtract control. Optional per-lane unsigned saturation. Result and
// per-segment carries are registered (one edge of latency), with a
// synchronous active-low reset. Assumes mode encodings from spa_pkg.
module spa_lane_adder
    import spa_pkg::*;
#(
    parameter int NSEG  = 8,
    parameter int SEG_W = 8,
    localparam int W    = NSEG * SEG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic            sub_i,
    input  logic            sat_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    sum_o,
    output logic [NSEG-1:0] carry_o
);

    lane_mode_e      mode_e;
    logic [NSEG-1:0] start_mask;
    logic [NSEG-1:0] top_mask;
    logic [W-1:0]    b_eff;
    logic [W-1:0]    raw_sum;
    logic [W-1:0]    sat_sum;
    logic [NSEG-1:0] seg_cin;
    logic [NSEG-1:0] seg_cout;

    assign mode_e = lane_mode_e'(mode_i);

    // Operand B is inverted for subtraction (A + ~B + 1 per lane).
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
    end

    spa_boundary_ctl #(.NSEG(NSEG)) u_bound (
        .mode       (mode_e),
        .start_mask (start_mask),
        .top_mask   (top_mask)
    );

    for (genvar i = 0; i < NSEG; i++) begin : g_chain
        if (i == 0) begin : g_base
            // The bottom segment always begins a lane.
            assign seg_cin[i] = sub_i;
        end else begin : g_link
            // Cut the chain at lane starts; otherwise ripple from below.
            assign seg_cin[i] = start_mask[i] ? sub_i : seg_cout[i-1];
        end
        spa_seg_adder #(.SEG_W(SEG_W)) u_seg (
            .a    (a_i[i*SEG_W +: SEG_W]),
            .b    (b_eff[i*SEG_W +: SEG_W]),
            .cin  (seg_cin[i]),
            .sum  (raw_sum[i*SEG_W +: SEG_W]),
            .cout (seg_cout[i])
        );
    end

    spa_lane_sat #(.NSEG(NSEG), .SEG_W(SEG_W)) u_sat (
        .raw_sum   (raw_sum),
        .seg_carry (seg_cout),
        .top_mask  (top_mask),
        .sat_en    (sat_i),
        .sub_en    (sub_i),
        .sat_sum   (sat_sum)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o   <= '0;
            carry_o <= '0;
        end else begin
            sum_o   <= sat_sum;
            carry_o <= seg_cout;
        end
    end

    // ---------------- assertions ----------------
    logic primed_q;

    // Marks that the previous edge was out of reset, so $past inputs are live.
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // R1: reset clears both outputs at the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && carry_o == '0));

    // R3: full-width mode is plain modular addition / subtraction.
    a_r3_full_width: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode_i) == LANE_FULL && !$past(sat_i)) |->
        sum_o == ($past(a_i) + ($past(sub_i) ? ~$past(b_i) : $past(b_i))
                  + {{(W-1){1'b0}}, $past(sub_i)}));

    for (genvar k = 0; k < NSEG; k++) begin : g_chk
        // R4 / R7: in 8-bit mode each byte is independent of its neighbours.
        a_r4_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && $past(mode_i) == LANE_8 && !$past(sat_i)) |->
            {carry_o[k], sum_o[k*SEG_W +: SEG_W]} ==
                ({1'b0, $past(a_i[k*SEG_W +: SEG_W])}
                 + {1'b0, ($past(sub_i) ? ~$past(b_i[k*SEG_W +: SEG_W])
                                        :  $past(b_i[k*SEG_W +: SEG_W]))}
                 + {{SEG_W{1'b0}}, $past(sub_i)}));

        // R9: saturating add clamps an overflowing byte lane to all ones.
        a_r9_sat_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && $past(mode_i) == LANE_8 && $past(sat_i) && !$past(sub_i)
             && carry_o[k]) |-> sum_o[k*SEG_W +: SEG_W] == {SEG_W{1'b1}});

        // R10: saturating subtract clamps a borrowing byte lane to zero.
        a_r10_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (primed_q && $past(mode_i) == LANE_8 && $past(sat_i) && $past(sub_i)
             && !carry_o[k]) |-> sum_o[k*SEG_W +: SEG_W] == {SEG_W{1'b0}});
    end

endmodule

// File: tb/tb_spa_lane_adder.sv
// Bench for spa_lane_adder: a vector table walked by one loop, then directed
// reset and latency tests. Expected values come from a lane-by-lane model.
module tb_spa_lane_adder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        sub_i, sat_i;
    logic [63:0] a_i, b_i;
    logic [63:0] sum_o;
    logic [7:0]  carry_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spa_lane_adder dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sub_i(sub_i), .sat_i(sat_i),
        .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .carry_o(carry_o)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  mode;
        logic        sub;
        logic        sat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{64'h0123_4567_89AB_CDEF, 64'h1111_1111_1111_1111, 2'b00, 1'b0, 1'b0, 4'd3},  // R3
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b00, 1'b0, 1'b0, 4'd3},  // R3
        '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'b00, 1'b0, 1'b0, 4'd3},  // R3
        '{64'hFF01_7F80_00FF_1234, 64'h01FF_0180_0001_EDCB, 2'b11, 1'b0, 1'b0, 4'd4},  // R4
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b11, 1'b0, 1'b0, 4'd7},  // R7
        '{64'hFFFF_0001_8000_1234, 64'h0001_FFFF_8000_0FFF, 2'b01, 1'b0, 1'b0, 4'd5},  // R5
        '{64'h00FF_FF00_7FFF_ABCD, 64'h0001_0100_0001_5433, 2'b01, 1'b0, 1'b0, 4'd5},  // R5
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 1'b0, 1'b0, 4'd7},  // R7
        '{64'h1234_5678_FFFF_0000, 64'hEDCB_A988_0001_FFFF, 2'b10, 1'b0, 1'b0, 4'd6},  // R6
        '{64'h0510_FF00_8000_7F20, 64'h0720_0001_0001_7F10, 2'b11, 1'b1, 1'b0, 4'd8},  // R8
        '{64'h0000_0000_0000_0005, 64'h0000_0000_0000_0007, 2'b00, 1'b1, 1'b0, 4'd8},  // R8
        '{64'h1000_0000_FFFF_0100, 64'h0FFF_0001_FFFF_0200, 2'b01, 1'b1, 1'b0, 4'd8},  // R8
        '{64'hF080_7F01_FF00_C040, 64'h2080_0101_0100_40C0, 2'b11, 1'b0, 1'b1, 4'd9},  // R9
        '{64'hFFFF_1234_8000_0001, 64'h0001_1111_8000_FFFE, 2'b01, 1'b0, 1'b1, 4'd9},  // R9
        '{64'h1020_3040_0505_FF00, 64'h2010_4030_0605_00FF, 2'b11, 1'b1, 1'b1, 4'd10}, // R10
        '{64'h0000_0001_8000_0000, 64'h0000_0002_7FFF_FFFF, 2'b10, 1'b1, 1'b1, 4'd10}, // R10
        '{64'h1234_5678_9ABC_DEF0, 64'h0101_0101_0101_0101, 2'b00, 1'b0, 1'b1, 4'd11}, // R11
        '{64'h9999_9999_9999_9999, 64'h1111_1111_1111_1111, 2'b00, 1'b1, 1'b1, 4'd11}  // R11
    };

    function automatic string req_tag(input logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] low_mask(input int n);
        return (n >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
    endfunction

    // Independent lane model: every segment carry from a partial lane sum.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                         input logic sub, input logic sat,
                         output logic [63:0] s, output logic [7:0] c);
        int spl;
        logic [63:0] bb;
        case (m)
            2'b11: spl = 1;
            2'b01: spl = 2;
            2'b10: spl = 4;
            default: spl = 8;
        endcase
        bb = sub ? ~b : b;
        s = '0;
        c = '0;
        for (int l = 0; l < 8 / spl; l++) begin
            int lo;
            int w;
            logic [65:0] t;
            lo = l * spl * 8;
            w  = spl * 8;
            t  = '0;
            for (int j = 0; j < spl; j++) begin
                int n;
                n = (j + 1) * 8;
                t = {2'b00, (a >> lo) & low_mask(n)} + {2'b00, (bb >> lo) & low_mask(n)}
                    + {65'd0, sub};
                c[l*spl + j] = t[n];
            end
            if (sat && !sub && c[l*spl + spl - 1])     t[63:0] = 64'hFFFF_FFFF_FFFF_FFFF;
            else if (sat && sub && !c[l*spl + spl - 1]) t[63:0] = 64'd0;
            s = s | ((t[63:0] & low_mask(w)) << lo);
        end
    endtask

    task automatic check64(input string tag, input string what,
                           input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic check8(input string tag, input string what,
                          input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                         input logic sub, input logic sat);
        a_i = a; b_i = b; mode_i = m; sub_i = sub; sat_i = sat;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] es;
        logic [7:0]  ec;
        rst_n = 1'b0;
        drive(64'hDEAD_BEEF_0000_FFFF, 64'h1234_5678_9ABC_DEF0, 2'b00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset holds outputs at zero even with live operands.
        check64("R1", "sum in reset", sum_o, 64'd0);
        check8 ("R1", "carry in reset", carry_o, 8'd0);
        rst_n = 1'b1;

        // Table walk: drive on a falling edge, compare on the next one.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(VECS[v].a, VECS[v].b, VECS[v].mode, VECS[v].sub, VECS[v].sat);
            model(VECS[v].a, VECS[v].b, VECS[v].mode, VECS[v].sub, VECS[v].sat, es, ec);
            @(negedge clk);
            check64(req_tag(VECS[v].req), $sformatf("sum vec %0d", v), sum_o, es);
            check8 (req_tag(VECS[v].req), $sformatf("carry vec %0d", v), carry_o, ec);
        end

        // R11: saturation off/on give the same lane when nothing overflows.
        @(negedge clk);
        drive(64'h1020_3040_5060_7080, 64'h0101_0101_0101_0101, 2'b11, 1'b0, 1'b1);
        @(negedge clk);
        check64("R11", "sat no-overflow bytes", sum_o, 64'h1121_3141_5161_7181);

        // R2: result of a new vector is not visible before the capturing edge.
        @(negedge clk);
        drive(64'd10, 64'd20, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        check64("R2", "captured result", sum_o, 64'd30);
        drive(64'd100, 64'd1, 2'b00, 1'b0, 1'b0);
        #1;
        check64("R2", "held before edge", sum_o, 64'd30);
        @(negedge clk);
        check64("R2", "updated after edge", sum_o, 64'd101);

        // R1: reset in mid-run clears registered results.
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check64("R1", "sum after mid reset", sum_o, 64'd0);
        check8 ("R1", "carry after mid reset", carry_o, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: all-ones bytes added pairwise: each FE with carry.
        check64("R4", "sum after release", sum_o, 64'hFEFE_FEFE_FEFE_FEFE);
        check8 ("R4", "carry after release", carry_o, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule